// File: doc/BRIEF.md
# Speed-Scaled Data-Strobe Serialiser/Deserialiser

This block connects a parallel link-side data path to a multi-port serial cable interface that uses data-strobe bit encoding. A fast clock paces the serial side. A word boundary comes every `MAX_W` fast cycles, and a word carries 2, 4 or 8 significant bits depending on the selected packet speed. The serial bit rate therefore scales with the speed while the word rate stays fixed.

On transmit, a parallel word is taken at each word boundary. It is shifted out most significant bit first and encoded onto a data line and a strobe line, and every port drives the same stream. On receive, one selected port is listened to and its drivers are switched off. The block recovers bits from that port's line pair and forwards them, re-encoded, to every other port. It also packs the bits into words and passes them through a small elastic buffer, and the words are presented at the word boundaries.

Top module: `ds_serdes`

## Requirements
- R1: Speed code 0 selects 2 bits per word, code 1 selects 4 and codes 2 and 3 select 8. The significant bits are the uppermost ones of the word (S100 uses bits 7:6, S200 uses bits 7:4), and the lower bits are ignored.
- R2: `word_tick` is high for one cycle in every 8. Serial bits last 4, 2 or 1 cycles at codes 0, 1 and 2.
- R3: Each word is sent most significant bit first.
- R4: Transmit data appears on `tpb_out` and strobe on `tpa_out`. From one bit to the next, exactly one of the two lines changes.
- R5: `tx_en` is sampled only in the `word_tick` cycle. While transmit is idle, `drv_en` is 0 and both lines are 0.
- R6: On receive, data is on `rx_a` and strobe on `rx_b` of the port chosen by `rx_sel`. A bit with the value of `rx_a` is recovered on every change of `rx_a` XOR `rx_b`.
- R7: A received word holds its bits MSB-aligned. It appears on `rx_data` with `rx_valid` high for exactly the one cycle that follows a `word_tick`.
- R8: Output starts once two words are buffered. Matched input and output rates then deliver words in order, with neither flag raised.
- R9: A word that completes while the 4-entry buffer is full is dropped, and `rx_ovf` pulses for one cycle.
- R10: A `word_tick` that finds the buffer primed but empty pulses `rx_udf`. Lowering `rx_en` flushes the buffer and clears priming.
- R11: While `rx_en` is high, the drivers of the receiving port are off and its lines are 0.
- R12: While `rx_en` is high, every other port drives the recovered bits, re-encoded, at the received bit spacing.
- R13: After reset, drivers are off, all lines are 0, and `rx_valid`, `rx_ovf` and `rx_udf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed | input | 2 | Packet speed code |
| tx_en | input | 1 | Transmit request, sampled at word boundaries |
| tx_data | input | 8 | Parallel word to send |
| word_tick | output | 1 | Word boundary marker |
| rx_en | input | 1 | Receive mode; held steady speed while high |
| rx_sel | input | 2 | Index of receiving port |
| rx_a | input | 3 | Per-port received data line |
| rx_b | input | 3 | Per-port received strobe line |
| tpa_out | output | 3 | Per-port strobe line driven |
| tpb_out | output | 3 | Per-port data line driven |
| drv_en | output | 3 | Per-port driver enable |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 8 | Received word |
| rx_ovf | output | 1 | Buffer overflow pulse |
| rx_udf | output | 1 | Buffer underflow pulse |

## Verification
The first transmitted bit reaches the lines at the clock edge that ends the `word_tick` cycle, and each later bit follows 4, 2 or 1 cycles after the previous one. A received line change reaches the repeating ports two edges later, and a packed word leaves the buffer one cycle after a `word_tick`. The monitor samples at falling edges and acts on events: it decodes each port's lines whenever the parity changes and compares the bit with the scoreboard. It also checks the gap to the previous bit against the expected spacing. For every `rx_valid` it confirms that `word_tick` was high in the cycle before, so each latency is checked without fixed waits.

// File: rtl/ds_pkg.sv
// Shared types and helpers for the data-strobe serdes.
package ds_pkg;
    typedef enum logic [1:0] {
        SPD_S100 = 2'd0,
        SPD_S200 = 2'd1,
        SPD_S400 = 2'd2,
        SPD_SX   = 2'd3
    } speed_e;

    // Strobe value that keeps data XOR strobe toggling for each new bit.
    function automatic logic strobe_next(input logic prev_d, input logic prev_s,
                                         input logic new_d);
        return (new_d == prev_d) ? ~prev_s : prev_s;
    endfunction
endpackage

// File: rtl/ds_rate_gen.sv
// Word/bit pacing. Assumes MAX_W is a power of two and at least 4.
// word_tick marks the last cycle of each word; bit_en marks the last
// cycle of each serial bit slot, so word_tick always coincides with bit_en.
module ds_rate_gen
    import ds_pkg::*;
#(
    parameter int MAX_W = 8,
    localparam int PW = $clog2(MAX_W),
    localparam int CW = $clog2(MAX_W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  speed_e        speed,
    output logic          word_tick,
    output logic          bit_en,
    output logic [CW-1:0] bits
);
    logic [PW-1:0] ph;
    logic [1:0]    sh;
    logic [PW-1:0] mask;

    // Map speed to a down-shift of the word width.
    always_comb begin
        case (speed)
            SPD_S100: sh = 2'd2;
            SPD_S200: sh = 2'd1;
            default:  sh = 2'd0;
        endcase
        mask = (PW'(1) << sh) - PW'(1);
        bits = CW'(MAX_W) >> sh;
    end

    // Free-running phase within a word.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + PW'(1);
    end

    assign word_tick = (ph == {PW{1'b1}});
    assign bit_en    = ((ph & mask) == mask);
endmodule

// File: rtl/ds_serialiser.sv
// Parallel-to-serial with data-strobe encoding. A word is loaded at each
// word_tick when tx_en is high; the MSB goes out at once and the rest on
// later bit slots. Bits beyond the speed's width are overwritten by the next load.
module ds_serialiser
    import ds_pkg::*;
#(
    parameter int MAX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_tick,
    input  logic             bit_en,
    input  logic             tx_en,
    input  logic [MAX_W-1:0] tx_word,
    output logic             ser_d,
    output logic             ser_s,
    output logic             active
);
    logic [MAX_W-1:0] sr;

    // Load, shift and encode the outgoing stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0; ser_d <= 1'b0; ser_s <= 1'b0; active <= 1'b0;
        end else if (word_tick) begin
            if (tx_en) begin
                active <= 1'b1;
                ser_d  <= tx_word[MAX_W-1];
                ser_s  <= strobe_next(ser_d, ser_s, tx_word[MAX_W-1]);
                sr     <= tx_word << 1;
            end else begin
                active <= 1'b0; ser_d <= 1'b0; ser_s <= 1'b0;
            end
        end else if (bit_en && active) begin
            ser_d <= sr[MAX_W-1];
            ser_s <= strobe_next(ser_d, ser_s, sr[MAX_W-1]);
            sr    <= sr << 1;
        end
    end

    // R4: between consecutive active cycles at most one line changes.
    a_r4_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |->
            ($countones({ser_d ^ $past(ser_d), ser_s ^ $past(ser_s)}) <= 1));
endmodule

// File: rtl/ds_deserialiser.sv
// Recovers bits from a data/strobe pair (new bit on each parity change)
// and packs them into MSB-aligned words. Assumes lines change at most once per
// clock, and that bits (speed) is steady while rx_en is high.
module ds_deserialiser #(
    parameter int MAX_W = 8,
    localparam int CW = $clog2(MAX_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [CW-1:0]    bits,
    input  logic             line_a,
    input  logic             line_b,
    output logic             bit_stb,
    output logic             bit_val,
    output logic             push,
    output logic [MAX_W-1:0] push_word
);
    logic          a_r, b_r, par_r;
    logic [CW-1:0] bc;
    logic [MAX_W-1:0] sh;
    logic [MAX_W-1:0] nxt;

    // Register the lines and keep the previous parity as the clock reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r <= 1'b0; b_r <= 1'b0; par_r <= 1'b0;
        end else begin
            a_r <= line_a; b_r <= line_b; par_r <= a_r ^ b_r;
        end
    end

    assign bit_stb = rx_en && ((a_r ^ b_r) != par_r);
    assign bit_val = a_r;
    assign nxt     = {sh[MAX_W-2:0], a_r};

    // Pack recovered bits into words of the current width.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            bc <= '0; sh <= '0; push <= 1'b0; push_word <= '0;
        end else begin
            push <= 1'b0;
            if (bit_stb) begin
                sh <= nxt;
                if (bc == bits - CW'(1)) begin
                    push      <= 1'b1;
                    push_word <= nxt << (CW'(MAX_W) - bits);
                    bc        <= '0;
                end else begin
                    bc <= bc + CW'(1);
                end
            end
        end
    end

    // R6: the bit counter never reaches the word width.
    a_r6_count_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> (bc < bits));
endmodule

// File: rtl/ds_elastic_fifo.sv
// Elastic buffer between packed receive words and word-tick output.
// Output starts once PRIME entries are held; pulses flag overflow/underflow.
// Assumes DEPTH is a power of two and pop_req is never high two cycles running.
module ds_elastic_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int NW    = $clog2(DEPTH) + 1,
    localparam int PRIME = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop_req,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic          ovf,
    output logic          udf
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [NW-1:0] count;
    logic          primed, full, empty, do_push, do_pop;

    assign full    = (count == NW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop_req && primed && !empty;

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    // Pointers, level, priming and flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp <= '0; rp <= '0; count <= '0; primed <= 1'b0;
            rvalid <= 1'b0; ovf <= 1'b0; udf <= 1'b0;
            if (!rst_n) rdata <= '0;
        end else begin
            rvalid <= do_pop;
            ovf    <= push && full;
            udf    <= pop_req && primed && empty;
            if (do_push) wp <= wp + AW'(1);
            if (do_pop) begin
                rdata <= mem[rp];
                rp    <= rp + AW'(1);
            end
            if (do_push && !do_pop)      count <= count + NW'(1);
            else if (do_pop && !do_push) count <= count - NW'(1);
            if (count >= NW'(PRIME)) primed <= 1'b1;
        end
    end

    // R8: the level never exceeds the depth.
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= NW'(DEPTH));
    // R9: a dropped word leaves the buffer full.
    a_r9_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (push && full && !(pop_req && primed)) |=> full);
    // R10: underflow only follows an empty buffer.
    a_r10_udf_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        udf |-> ($past(count) == '0));
    // R7: a delivered word is a single-cycle pulse.
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/ds_serdes.sv
// Top level: pacing, transmit serialiser, receive recovery with repeat to the
// other ports, and the receive elastic buffer. Receive mode has priority over
// transmit; the receiving port's drivers are off while rx_en is high.
module ds_serdes
    import ds_pkg::*;
#(
    parameter int MAX_W  = 8,
    parameter int NPORTS = 3,
    parameter int DEPTH  = 4,
    localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int CW     = $clog2(MAX_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        speed,
    input  logic              tx_en,
    input  logic [MAX_W-1:0]  tx_data,
    output logic              word_tick,
    input  logic              rx_en,
    input  logic [PSEL_W-1:0] rx_sel,
    input  logic [NPORTS-1:0] rx_a,
    input  logic [NPORTS-1:0] rx_b,
    output logic [NPORTS-1:0] tpa_out,
    output logic [NPORTS-1:0] tpb_out,
    output logic [NPORTS-1:0] drv_en,
    output logic              rx_valid,
    output logic [MAX_W-1:0]  rx_data,
    output logic              rx_ovf,
    output logic              rx_udf
);
    logic          bit_en, ser_d, ser_s, tx_act;
    logic [CW-1:0] bits;
    logic          sel_a, sel_b, bit_stb, bit_val, push;
    logic [MAX_W-1:0] push_word;
    logic          rep_d, rep_s;

    ds_rate_gen #(.MAX_W(MAX_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .speed(speed_e'(speed)),
        .word_tick(word_tick), .bit_en(bit_en), .bits(bits));

    ds_serialiser #(.MAX_W(MAX_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .word_tick(word_tick), .bit_en(bit_en),
        .tx_en(tx_en), .tx_word(tx_data), .ser_d(ser_d), .ser_s(ser_s),
        .active(tx_act));

    // Pick the line pair of the receiving port.
    always_comb begin
        sel_a = 1'b0;
        sel_b = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (rx_sel == PSEL_W'(i)) begin
                sel_a = rx_a[i];
                sel_b = rx_b[i];
            end
        end
    end

    ds_deserialiser #(.MAX_W(MAX_W)) u_des (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bits(bits),
        .line_a(sel_a), .line_b(sel_b), .bit_stb(bit_stb), .bit_val(bit_val),
        .push(push), .push_word(push_word));

    ds_elastic_fifo #(.DW(MAX_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push),
        .wdata(push_word), .pop_req(word_tick && rx_en), .rvalid(rx_valid),
        .rdata(rx_data), .ovf(rx_ovf), .udf(rx_udf));

    // Re-encode recovered bits for the repeating ports.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            rep_d <= 1'b0; rep_s <= 1'b0;
        end else if (bit_stb) begin
            rep_d <= bit_val;
            rep_s <= strobe_next(rep_d, rep_s, bit_val);
        end
    end

    // Per-port driver enables and line multiplexing.
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign drv_en[g]  = rx_en ? (rx_sel != PSEL_W'(g)) : tx_act;
        assign tpa_out[g] = drv_en[g] & (rx_en ? rep_s : ser_s);
        assign tpb_out[g] = drv_en[g] & (rx_en ? rep_d : ser_d);
    end

    // R11: a port held in receive stays silent.
    a_r11_rx_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en) && $stable(rx_sel)) |->
            (tpa_out[rx_sel] == 1'b0 && tpb_out[rx_sel] == 1'b0));
endmodule

// File: tb/ds_serdes_bench.sv
module ds_serdes_bench;
    localparam int NP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] speed = 2'd2;
    logic tx_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic rx_en = 1'b0;
    logic [1:0] rx_sel = 2'd0;
    logic [NP-1:0] rx_a = '0, rx_b = '0;
    logic word_tick, rx_valid, rx_ovf, rx_udf;
    logic [NP-1:0] tpa, tpb, drv_en;
    logic [7:0] rx_data;

    ds_serdes u_ds_serdes (
        .clk(clk), .rst_n(rst_n), .speed(speed), .tx_en(tx_en), .tx_data(tx_data),
        .word_tick(word_tick), .rx_en(rx_en), .rx_sel(rx_sel), .rx_a(rx_a),
        .rx_b(rx_b), .tpa_out(tpa), .tpb_out(tpb), .drv_en(drv_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ovf(rx_ovf), .rx_udf(rx_udf));

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done = 0;

    // Scoreboard state.
    logic [7:0] exp_words[$];
    logic exp_bits [0:1023];
    int exp_n = 0;
    int idx [NP];
    int last_cyc [NP];
    logic pref [NP], pa [NP], pb [NP];
    int cyc = 0, exp_space = 0, r11_bad = 0, ovf_cnt = 0, udf_cnt = 0;
    bit mon_on = 0, sb_on = 0;
    string cur_tag = "R3";
    logic tick_prev = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic sb_clear();
        exp_n = 0;
        exp_words.delete();
        for (int p = 0; p < NP; p++) begin idx[p] = 0; last_cyc[p] = 0; end
        r11_bad = 0; ovf_cnt = 0; udf_cnt = 0;
    endtask

    // Monitor: decode every driven port, compare words and timing.
    always @(negedge clk) begin
        cyc++;
        for (int p = 0; p < NP; p++) begin
            if (!drv_en[p]) begin
                pref[p] = 1'b0; pa[p] = 1'b0; pb[p] = 1'b0;
            end else begin
                if (tpa[p] != pa[p] && tpb[p] != pb[p])
                    check(0, "R4", {tpa[p], tpb[p]}, {pa[p], pb[p]});
                if ((tpa[p] ^ tpb[p]) != pref[p]) begin
                    if (mon_on) begin
                        if (idx[p] < exp_n)
                            check(tpb[p] == exp_bits[idx[p]], cur_tag, tpb[p], exp_bits[idx[p]]);
                        else
                            check(0, cur_tag, idx[p], exp_n);
                        if (exp_space > 0 && idx[p] > 0)
                            check(cyc - last_cyc[p] == exp_space, "R2", cyc - last_cyc[p], exp_space);
                    end
                    idx[p]++;
                    last_cyc[p] = cyc;
                end
                pref[p] = tpa[p] ^ tpb[p]; pa[p] = tpa[p]; pb[p] = tpb[p];
            end
        end
        if (rx_en && (drv_en[rx_sel] || tpa[rx_sel] || tpb[rx_sel])) r11_bad++;
        if (rx_valid && sb_on) begin
            check(tick_prev == 1'b1, "R7", tick_prev, 1);
            if (exp_words.size() == 0) check(0, "R8", rx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_words.pop_front();
                check(rx_data == e, "R6", rx_data, e);
            end
        end
        if (rx_ovf) ovf_cnt++;
        if (rx_udf) udf_cnt++;
        tick_prev = word_tick;
    end

    // Transmit driver: present one word at a word boundary.
    task automatic tx_word(input logic [7:0] w, input int nb);
        @(negedge clk);
        while (!word_tick) @(negedge clk);
        tx_data = w;
        tx_en = 1'b1;
        for (int k = 0; k < nb; k++) begin exp_bits[exp_n] = w[7-k]; exp_n++; end
    endtask

    task automatic tx_stop();
        @(negedge clk);
        while (!word_tick) @(negedge clk);
        tx_en = 1'b0;
        tx_data = 8'h00;
        repeat (20) @(negedge clk);
    endtask

    // Receive driver: one data-strobe bit on port p for hold cycles.
    task automatic rx_bit(input int p, input logic v, input int hold);
        logic nb;
        nb = (v == rx_a[p]) ? ~rx_b[p] : rx_b[p];
        @(negedge clk);
        rx_a[p] = v;
        rx_b[p] = nb;
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic rx_word(input int p, input logic [7:0] w, input int nb, input int hold);
        for (int k = 0; k < nb; k++) begin
            exp_bits[exp_n] = w[7-k]; exp_n++;
            rx_bit(p, w[7-k], hold);
        end
        exp_words.push_back(w & (8'hFF << (8 - nb)));
    endtask

    task automatic tx_check_ports(input string tag);
        for (int p = 0; p < NP; p++) check(idx[p] == exp_n, tag, idx[p], exp_n);
        // R5: idle after the last word
        check(drv_en == '0 && tpa == '0 && tpb == '0, "R5", {drv_en, tpa, tpb}, 0);
    endtask

    task automatic rx_start(input int p, input logic [1:0] spd);
        sb_clear();
        speed = spd;
        rx_sel = 2'(p);
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_drain();
        for (int t = 0; t < 200 && exp_words.size() != 0; t++) @(negedge clk);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_check(input int p);
        check(exp_words.size() == 0, "R8", exp_words.size(), 0);
        check(ovf_cnt == 0 && udf_cnt == 0, "R8", ovf_cnt + udf_cnt, 0);
        check(r11_bad == 0, "R11", r11_bad, 0);
        check(idx[p] == 0, "R11", idx[p], 0);
        for (int q = 0; q < NP; q++)
            if (q != p) check(idx[q] == exp_n, "R12", idx[q], exp_n);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin pref[p] = 0; pa[p] = 0; pb[p] = 0; end
        sb_clear();
        repeat (5) @(negedge clk);
        // R13: reset state
        check(drv_en == '0 && tpa == '0 && tpb == '0, "R13", {drv_en, tpa, tpb}, 0);
        check(!rx_valid && !rx_ovf && !rx_udf, "R13", {rx_valid, rx_ovf, rx_udf}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(drv_en == '0 && !rx_valid, "R13", {drv_en, rx_valid}, 0);

        // R3: S400, eight bits per word, MSB first, one cycle each (R2)
        mon_on = 1; cur_tag = "R3"; speed = 2'd2; exp_space = 1;
        tx_word(8'hA5, 8); tx_word(8'h3C, 8); tx_word(8'hFF, 8); tx_word(8'h00, 8);
        tx_stop();
        tx_check_ports("R3");

        // R1: S200 uses bits 7:4, two cycles per bit
        sb_clear(); cur_tag = "R1"; speed = 2'd1; exp_space = 2;
        tx_word(8'h9C, 4); tx_word(8'h6F, 4); tx_word(8'h12, 4);
        tx_stop();
        tx_check_ports("R1");

        // R1: S100 uses bits 7:6, four cycles per bit
        sb_clear(); speed = 2'd0; exp_space = 4;
        tx_word(8'hC3, 2); tx_word(8'h7E, 2); tx_word(8'h80, 2); tx_word(8'hFF, 2);
        tx_stop();
        tx_check_ports("R1");

        // R6/R12: receive at S400 on port 0
        cur_tag = "R12"; sb_on = 1;
        rx_start(0, 2'd2); exp_space = 1;
        rx_word(0, 8'h5A, 8, 1); rx_word(0, 8'hC1, 8, 1); rx_word(0, 8'h0F, 8, 1);
        rx_word(0, 8'hE7, 8, 1); rx_word(0, 8'h24, 8, 1);
        rx_drain();
        rx_check(0);

        // R6: receive at S100 on port 2
        rx_start(2, 2'd0); exp_space = 4;
        rx_word(2, 8'h80, 2, 4); rx_word(2, 8'h40, 2, 4); rx_word(2, 8'hC0, 2, 4);
        rx_word(2, 8'h00, 2, 4); rx_word(2, 8'hFF, 2, 4);
        rx_drain();
        rx_check(2);

        // R6: receive at S200 on port 1
        rx_start(1, 2'd1); exp_space = 2;
        rx_word(1, 8'hA0, 4, 2); rx_word(1, 8'h50, 4, 2); rx_word(1, 8'hF0, 4, 2);
        rx_word(1, 8'h30, 4, 2);
        rx_drain();
        rx_check(1);

        // R10: stream stops while receive stays on
        rx_start(0, 2'd1); exp_space = 2;
        rx_word(0, 8'h90, 4, 2); rx_word(0, 8'h60, 4, 2); rx_word(0, 8'hB0, 4, 2);
        repeat (48) @(negedge clk);
        check(udf_cnt > 0, "R10", udf_cnt, 1);
        check(exp_words.size() == 0, "R10", exp_words.size(), 0);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        check(!rx_udf && !rx_valid, "R10", {rx_udf, rx_valid}, 0);

        // R9: bits arrive four times faster than words leave
        rx_start(0, 2'd0);
        mon_on = 0; sb_on = 0; exp_space = 0;
        for (int k = 0; k < 64; k++) rx_bit(0, logic'(k[1] ^ k[0]), 1);
        repeat (4) @(negedge clk);
        check(ovf_cnt > 0, "R9", ovf_cnt, 1);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        check(!rx_ovf && !rx_valid, "R9", {rx_ovf, rx_valid}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected 0 (run hung)", 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule